// File: doc/BRIEF.md
# Automatic Crossover Sequencer

This block decides, with no software involved, whether the transmit and receive pairs of a copper Ethernet port need to be swapped. It drives a crossover-select line and learns the state of the PHY only by issuing register reads through a simple MDIO command/response interface. The MDIO master itself sits outside the block.

After a start pulse the sequencer runs two phases. In the first phase it reads the PHY's energy-detect register back to back until the PHY reports that a signal is present. In the second phase it first forces straight (MDI) mode. It then waits a fixed interval, reads the PHY's basic status register and checks the link bit. If there is no link it flips the select line and tries again. Each phase has a bound on its attempts. Hitting a bound ends the sequence with a failure; seeing link ends it with success and keeps the mode that worked.

A read is requested by a one-cycle pulse on `mdioReq`, with the PHY and register numbers presented alongside it. The MDIO master must raise `mdioPending` by the cycle after the pulse and hold it high until `mdioRdData` is valid. The interval is a count of clock cycles, `INTERVAL_CYCLES`. Its default is 300 ms at 100 MHz, and it is shortened for simulation.

Top module: `xover_top`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `fail`, `mdioReq` and `xoverSel` are all 0.
- R2: A start pulse while idle makes `busy` rise and issues a read of register 17 at PHY address 6. Every read request is a single-cycle pulse on `mdioReq`.
- R3: The read data is used only in a cycle where `mdioPending` is 0; data present while pending is high is ignored. The signal-detect test is bit 1 of the register 17 data, and the sequencer reads register 1 only after that bit has been seen set.
- R4: If bit 1 is still clear after `MAX_TRIES` reads of register 17, the sequence ends with `fail`. No read of register 1 is made, and `xoverSel` keeps the value it had before the start.
- R5: When signal detect is seen, `xoverSel` is driven to 0 (straight MDI) before the first link read.
- R6: Every read of register 1 at PHY address 6 is preceded by exactly `INTERVAL_CYCLES` cycles with neither a request nor a pending response. Its link test is bit 2 of the returned data.
- R7: A link read with bit 2 clear, when another attempt remains, inverts `xoverSel` before the next attempt. The k-th link read is therefore made with `xoverSel` equal to (k-1) mod 2.
- R8: A link read with bit 2 set ends the sequence with `done`. After that, `xoverSel` holds its value and no further reads are issued while idle.
- R9: After `MAX_TRIES` link reads all showing bit 2 clear, the sequence ends with `fail`, and `xoverSel` is not inverted after the last read.
- R10: A start pulse while `busy` is 1 has no effect on the sequence in progress.
- R11: `done` and `fail` are never both 1. Each holds until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence found link |
| fail | output | 1 | Last sequence ran out of attempts |
| xoverSel | output | 1 | Pair select: 0 straight (MDI), 1 crossed (MDIX) |
| mdioReq | output | 1 | One-cycle read request to the MDIO master |
| mdioPhyAddr | output | 5 | PHY address of the request |
| mdioRegAddr | output | 5 | Register number of the request |
| mdioPending | input | 1 | Request flag read back; high until data is valid |
| mdioRdData | input | 16 | Read data returned by the MDIO master |

## Verification
The bound checker checks on every cycle the properties that do not depend on a whole run:
- requests are single pulses and never overlap a pending response;
- no request is issued while idle;
- the select line moves only while busy;
- `done` and `fail` are exclusive and are held;
- an accepted start clears both status flags.

Only the bench scenarios can show the sequence-level behaviour:
- which register is read in which phase, and that the bit under test is the right one (the other data bits are driven to the opposite value);
- the exact gap before each link read;
- the alternation of the select line across attempts;
- the attempt bounds in each phase;
- that a start during a run leaves the outcome unchanged.

// File: rtl/xover_pkg.sv
package xover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIG_REQ,
    ST_SIG_WAIT,
    ST_LNK_DELAY,
    ST_LNK_REQ,
    ST_LNK_WAIT,
    ST_DONE,
    ST_FAIL
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrTry;
    logic incTry;
    logic loadDelay;
    logic decDelay;
    logic selMdi;
    logic selFlip;
    logic clrStatus;
    logic setDone;
    logic setFail;
  } dpCmd_t;

endpackage

// File: rtl/xover_dp.sv
module xover_dp
  import xover_pkg::*;
#(
  parameter int MAX_TRIES       = 100,
  parameter int INTERVAL_CYCLES = 30_000_000
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   tryLast,
  output logic   delayZero,
  output logic   xoverSel,
  output logic   done,
  output logic   fail
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int DLY_W = (INTERVAL_CYCLES > 2) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_TRIES);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(INTERVAL_CYCLES - 1);

  logic [TRY_W-1:0] tryCnt;
  logic [DLY_W-1:0] dlyCnt;

  // Attempt counter, shared by both phases
  always_ff @(posedge clk) begin
    if (!rstN)            tryCnt <= '0;
    else if (cmd.clrTry)  tryCnt <= '0;
    else if (cmd.incTry)  tryCnt <= tryCnt + 1'b1;
  end

  // Settling interval before each link read
  always_ff @(posedge clk) begin
    if (!rstN)               dlyCnt <= '0;
    else if (cmd.loadDelay)  dlyCnt <= DLY_LOAD;
    else if (cmd.decDelay)   dlyCnt <= dlyCnt - 1'b1;
  end

  // Pair select register
  always_ff @(posedge clk) begin
    if (!rstN)             xoverSel <= 1'b0;
    else if (cmd.selMdi)   xoverSel <= 1'b0;
    else if (cmd.selFlip)  xoverSel <= ~xoverSel;
  end

  // Outcome flags
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrStatus) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      if (cmd.setDone) done <= 1'b1;
      if (cmd.setFail) fail <= 1'b1;
    end
  end

  assign tryLast   = (tryCnt == TRY_MAX);
  assign delayZero = (dlyCnt == '0);

endmodule

// File: rtl/xover_ctrl.sv
module xover_ctrl
  import xover_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   mdioPending,
  input  logic   sigSeen,
  input  logic   linkSeen,
  input  logic   tryLast,
  input  logic   delayZero,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   mdioReq,
  output logic   inLinkPhase
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          nextState     = ST_SIG_REQ;
          cmd.clrTry    = 1'b1;
          cmd.clrStatus = 1'b1;
        end
      end
      ST_SIG_REQ: begin
        cmd.incTry = 1'b1;
        nextState  = ST_SIG_WAIT;
      end
      ST_SIG_WAIT: begin
        if (!mdioPending) begin
          if (sigSeen) begin
            cmd.selMdi    = 1'b1;
            cmd.clrTry    = 1'b1;
            cmd.loadDelay = 1'b1;
            nextState     = ST_LNK_DELAY;
          end else if (tryLast) begin
            cmd.setFail = 1'b1;
            nextState   = ST_FAIL;
          end else begin
            nextState = ST_SIG_REQ;
          end
        end
      end
      ST_LNK_DELAY: begin
        if (delayZero) nextState = ST_LNK_REQ;
        else           cmd.decDelay = 1'b1;
      end
      ST_LNK_REQ: begin
        cmd.incTry = 1'b1;
        nextState  = ST_LNK_WAIT;
      end
      ST_LNK_WAIT: begin
        if (!mdioPending) begin
          if (linkSeen) begin
            cmd.setDone = 1'b1;
            nextState   = ST_DONE;
          end else if (tryLast) begin
            cmd.setFail = 1'b1;
            nextState   = ST_FAIL;
          end else begin
            cmd.selFlip   = 1'b1;
            cmd.loadDelay = 1'b1;
            nextState     = ST_LNK_DELAY;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy        = !(state inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign mdioReq     = (state == ST_SIG_REQ) || (state == ST_LNK_REQ);
  assign inLinkPhase = state inside {ST_LNK_DELAY, ST_LNK_REQ, ST_LNK_WAIT};

endmodule

// File: rtl/xover_top.sv
module xover_top
  import xover_pkg::*;
#(
  parameter int PHY_ADDR        = 6,
  parameter int SIG_REG         = 17,
  parameter int SIG_BIT         = 1,
  parameter int LINK_REG        = 1,
  parameter int LINK_BIT        = 2,
  parameter int MAX_TRIES       = 100,
  parameter int INTERVAL_CYCLES = 30_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        xoverSel,
  output logic        mdioReq,
  output logic [4:0]  mdioPhyAddr,
  output logic [4:0]  mdioRegAddr,
  input  logic        mdioPending,
  input  logic [15:0] mdioRdData
);

  dpCmd_t cmd;
  logic   tryLast, delayZero, inLinkPhase;
  logic   unusedData;

  assign unusedData = ^mdioRdData;

  xover_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .mdioPending (mdioPending),
    .sigSeen     (mdioRdData[SIG_BIT]),
    .linkSeen    (mdioRdData[LINK_BIT]),
    .tryLast     (tryLast),
    .delayZero   (delayZero),
    .cmd         (cmd),
    .busy        (busy),
    .mdioReq     (mdioReq),
    .inLinkPhase (inLinkPhase)
  );

  xover_dp #(
    .MAX_TRIES       (MAX_TRIES),
    .INTERVAL_CYCLES (INTERVAL_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .tryLast   (tryLast),
    .delayZero (delayZero),
    .xoverSel  (xoverSel),
    .done      (done),
    .fail      (fail)
  );

  assign mdioPhyAddr = 5'(PHY_ADDR);
  assign mdioRegAddr = inLinkPhase ? 5'(LINK_REG) : 5'(SIG_REG);

endmodule

// File: rtl/xover_chk.sv
module xover_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic fail,
  input logic xoverSel,
  input logic mdioReq,
  input logic mdioPending
);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    mdioReq |=> !mdioReq);

  assert_no_req_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    mdioPending |-> !mdioReq);

  assert_sel_only_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(xoverSel) |-> $past(busy));

  assert_idle_sel_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(xoverSel));

  assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioReq);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (!done && !fail));

  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_fail_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !done && !fail));

endmodule

bind xover_top xover_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .xoverSel    (xoverSel),
  .mdioReq     (mdioReq),
  .mdioPending (mdioPending)
);

// File: tb/tb_xover_top.sv
module tb_xover_top;

  localparam int TRIES = 4;
  localparam int GAP   = 12;

  typedef struct packed {
    logic [7:0] sigAt;    // register 17 read that shows bit 1 set (0: never)
    logic [7:0] linkAt;   // register 1 read that shows bit 2 set (0: never)
    logic [7:0] lat;      // extra cycles of pending per read
    logic       poke;     // extra start pulse while busy
    logic [7:0] expSig;
    logic [7:0] expLink;
    logic       expDone;
    logic       expFail;
    logic       expSel;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd1, 8'd1, 8'd2, 1'b0, 8'd1, 8'd1, 1'b1, 1'b0, 1'b0},
    '{8'd3, 8'd2, 8'd0, 1'b1, 8'd3, 8'd2, 1'b1, 1'b0, 1'b1},
    '{8'd2, 8'd4, 8'd3, 1'b0, 8'd2, 8'd4, 1'b1, 1'b0, 1'b1},
    '{8'd0, 8'd0, 8'd1, 1'b0, 8'd4, 8'd0, 1'b0, 1'b1, 1'b1},
    '{8'd4, 8'd0, 8'd0, 1'b1, 8'd4, 8'd4, 1'b0, 1'b1, 1'b1},
    '{8'd1, 8'd3, 8'd1, 1'b0, 8'd1, 8'd3, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, fail, xoverSel, mdioReq;
  logic [4:0]  mdioPhyAddr, mdioRegAddr;
  logic        mdioPending = 1'b0;
  logic [15:0] mdioRdData = 16'hFFFF;

  int checks = 0;
  int failures = 0;

  // PHY model state
  int   curSigAt = 0, curLinkAt = 0, curLat = 0;
  int   sigCnt = 0, linkCnt = 0, gapCnt = 0, latCnt = 0;
  logic sigHit = 1'b0, armed = 1'b0;
  logic [15:0] resp = 16'h0000;

  always #5 clk = ~clk;

  xover_top #(
    .MAX_TRIES       (TRIES),
    .INTERVAL_CYCLES (GAP)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .xoverSel    (xoverSel),
    .mdioReq     (mdioReq),
    .mdioPhyAddr (mdioPhyAddr),
    .mdioRegAddr (mdioRegAddr),
    .mdioPending (mdioPending),
    .mdioRdData  (mdioRdData)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // MDIO master and PHY model; samples and drives at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      mdioPending = 1'b0;
      armed = 1'b0;
    end else if (mdioReq) begin
      chk(mdioPhyAddr == 5'd6, "R2 phy address", int'(mdioPhyAddr), 6);
      if (mdioRegAddr == 5'd17) begin
        chk(!sigHit, "R3 no signal read after detect", int'(sigHit), 0);
        sigCnt++;
        sigHit = (sigCnt == curSigAt);
        resp = sigHit ? 16'h0002 : 16'hFFFD;
      end else if (mdioRegAddr == 5'd1) begin
        chk(sigHit, "R3 link read only after detect", int'(sigHit), 1);
        linkCnt++;
        chk(xoverSel == 1'((linkCnt - 1) % 2), "R5 R7 select at link read",
            int'(xoverSel), (linkCnt - 1) % 2);
        chk(gapCnt == GAP, "R6 interval before link read", gapCnt, GAP);
        resp = (linkCnt == curLinkAt) ? 16'h0004 : 16'hFFFB;
      end else begin
        chk(1'b0, "R2 register address", int'(mdioRegAddr), 17);
      end
      armed = 1'b1;
      gapCnt = 0;
    end else if (mdioPending) begin
      gapCnt = 0;
      if (latCnt == 0) begin
        mdioPending = 1'b0;
        mdioRdData = resp;
      end else begin
        latCnt--;
      end
    end else if (armed) begin
      armed = 1'b0;
      mdioPending = 1'b1;
      latCnt = curLat;
      mdioRdData = ~resp;   // tested bit inverted while pending (R3)
      gapCnt = 0;
    end else begin
      gapCnt++;
    end
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitEnd(input string req);
    int n = 0;
    while (!(done || fail) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, req, n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R1: values during and after reset
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mdioReq && !xoverSel, "R1 during reset",
        int'({busy, done, fail, mdioReq, xoverSel}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !fail && !mdioReq && !xoverSel, "R1 after reset",
        int'({busy, done, fail, mdioReq, xoverSel}), 0);

    for (int i = 0; i < 6; i++) begin
      curSigAt  = int'(VECS[i].sigAt);
      curLinkAt = int'(VECS[i].linkAt);
      curLat    = int'(VECS[i].lat);
      sigCnt = 0;
      linkCnt = 0;
      sigHit = 1'b0;
      pulseStart();
      chk(busy, "R2 busy after start", int'(busy), 1);
      if (VECS[i].poke) begin
        repeat (3) @(negedge clk);
        start = 1'b1;               // R10: start while busy
        @(negedge clk) start = 1'b0;
      end
      waitEnd("R8 R9 sequence end");
      chk(done == VECS[i].expDone, "R8 done", int'(done), int'(VECS[i].expDone));
      chk(fail == VECS[i].expFail, "R4 R9 fail", int'(fail), int'(VECS[i].expFail));
      chk(xoverSel == VECS[i].expSel, "R4 R8 R9 select at end",
          int'(xoverSel), int'(VECS[i].expSel));
      chk(sigCnt == int'(VECS[i].expSig), "R4 R10 signal reads", sigCnt,
          int'(VECS[i].expSig));
      chk(linkCnt == int'(VECS[i].expLink), "R9 R10 link reads", linkCnt,
          int'(VECS[i].expLink));
      chk(!busy, "R11 not busy at end", int'(busy), 0);
    end

    // R8 R11: done held, no reads and select stable while idle
    repeat (40) @(negedge clk);
    chk(done && !fail, "R11 done held", int'({done, fail}), 2);
    chk(linkCnt == 3 && sigCnt == 1, "R8 no reads after done", linkCnt, 3);
    chk(xoverSel == 1'b0, "R8 select held", int'(xoverSel), 0);

    // R11: next start clears status; run that fails in phase 1
    curSigAt = 0;
    curLinkAt = 0;
    curLat = 0;
    sigCnt = 0;
    linkCnt = 0;
    sigHit = 1'b0;
    pulseStart();
    chk(!done && !fail && busy, "R11 start clears status",
        int'({busy, done, fail}), 4);
    waitEnd("R4 sequence end");
    chk(fail && !done, "R4 R11 fail only", int'({done, fail}), 1);
    repeat (20) @(negedge clk);
    chk(fail && !done, "R11 fail held", int'({done, fail}), 1);
    chk(sigCnt == TRIES && linkCnt == 0, "R4 bound without link read", sigCnt, TRIES);

    summary();
  end

endmodule